// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the datapath of a small 32-bit processor. Every register sits on one shared 32-bit internal bus. An external control sequencer raises load-enable and bus-output-enable strobes cycle by cycle, so that each clock moves one value from one source to any number of destinations. The registers are the program counter, the instruction register, a 16-entry general register bank, a memory address register, a memory data register with its own input selector, an ALU operand register (Y) with a constant-one input for incrementing the program counter, a 64-bit result register (Z) that can drive either half onto the bus, and two 32-bit registers that take the upper and lower halves of Z.

The general register bank has a single select decoder. The decoder takes a 4-bit index from one of three instruction fields, chosen by three pick strobes. When the instruction opcode is the jump-and-link code, the decoder is forced to the last register so that the program counter can be stored as the return address. Memory is seen only as an address output, a data output, a data input and a read strobe.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous active-low reset clears every register, including all 16 general registers. After reset each source puts 0 on the bus, and `mem_addr`, `mem_dout` and `ir_out` read 0.
- R2: The bus carries the value of the one source whose output enable is high. The sources are PC, MDR, Z upper, Z lower, HI, LO and the selected general register. With no enable high the bus reads 0. At most one enable is high in any cycle.
- R3: PC, IR and MAR load the bus value at a clock edge when their load enable is high and hold otherwise. `ir_out` shows IR and `mem_addr` shows MAR.
- R4: When `ld_mdr` is high, MDR loads `mem_din` if `mem_rd` is 1 and loads the bus if `mem_rd` is 0. `mem_dout` shows MDR.
- R5: When `ld_y` is high, Y loads the constant 1 if `y_one` is 1, or otherwise the bus. Y, then ADD with PC on the bus, then Z lower back into PC increments PC by one.
- R6: The register index is IR[26:23] when `pick_a` is high, otherwise IR[22:19] when `pick_b` is high, otherwise IR[18:15] when `pick_c` is high, otherwise 0. The same index serves `ld_gpr` and `oe_gpr`.
- R7: When IR[31:27] equals 5'b10100, the register index is 15 whatever the pick strobes and fields are. A write then goes to R15 and no other register changes.
- R8: `ld_z` loads Z from the ALU with A = Y and B = bus. The codes are 0 ADD (A+B), 1 SUB (A−B), 4 AND, 5 OR, 6 XOR and 7 NOT (~B). Each of these gives a 32-bit result, sign-extended to 64 bits.
- R9: Code 2 is MUL. It writes the full 64-bit signed product of A and B into Z.
- R10: Code 3 is DIV. It writes the signed remainder into Z[63:32] and the signed quotient, truncated toward zero, into Z[31:0]. A zero divisor gives Z = 0.
- R11: `ld_hi` loads HI from Z[63:32] and `ld_lo` loads LO from Z[31:0].
- R12: Operation codes 8 to 15 write 0 into Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_pc | input | 1 | Load PC from bus |
| ld_ir | input | 1 | Load IR from bus |
| ld_mar | input | 1 | Load MAR from bus |
| ld_mdr | input | 1 | Load MDR through its input selector |
| ld_y | input | 1 | Load Y through its input selector |
| ld_z | input | 1 | Load Z from the ALU |
| ld_hi | input | 1 | Load HI from Z upper half |
| ld_lo | input | 1 | Load LO from Z lower half |
| ld_gpr | input | 1 | Write the selected general register from bus |
| oe_pc | input | 1 | PC drives bus |
| oe_mdr | input | 1 | MDR drives bus |
| oe_zhi | input | 1 | Z[63:32] drives bus |
| oe_zlo | input | 1 | Z[31:0] drives bus |
| oe_hi | input | 1 | HI drives bus |
| oe_lo | input | 1 | LO drives bus |
| oe_gpr | input | 1 | Selected general register drives bus |
| pick_a | input | 1 | Select register index field IR[26:23] |
| pick_b | input | 1 | Select register index field IR[22:19] |
| pick_c | input | 1 | Select register index field IR[18:15] |
| mem_rd | input | 1 | 1: MDR takes memory data; 0: MDR takes bus |
| y_one | input | 1 | 1: Y takes constant 1; 0: Y takes bus |
| alu_op | input | 4 | ALU operation code |
| mem_din | input | 32 | Data from memory |
| mem_addr | output | 32 | MAR contents |
| mem_dout | output | 32 | MDR contents |
| ir_out | output | 32 | IR contents, for the sequencer |
| bus_out | output | 32 | Current internal bus value |

## Verification
Every register is seen at the ports only by driving it onto the bus, so a wrong internal value shows in the bus value once the sequencer enables that source. In this bench that happens one cycle after the faulty load. A wrong register-select decode shows up later, when a register that should not have been written is read back with a changed value, or when the target register reads back unchanged. ALU faults appear in the Z halves in the cycle after `ld_z`. HI and LO faults appear one load later.

// File: rtl/sbus_pkg.sv
// Shared widths and ALU operation codes for the single-bus datapath.
package sbus_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_GPR = 16;
    localparam int OPC_W = 5;
    localparam logic [OPC_W-1:0] OPC_LINK = 5'b10100;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7
    } alu_op_e;
endpackage

// File: rtl/sbus_bus_mux.sv
// Bus source selector: ORs together the sources whose enable is high.
// Assumes at most one enable is high; with none high the result is 0.
module sbus_bus_mux #(
    parameter int W = 32,
    parameter int N = 7
) (
    input  logic [N-1:0]   en,
    input  logic [N*W-1:0] src,
    output logic [W-1:0]   bus
);
    // Masked OR of all sources
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | (src[i*W +: W] & {W{en[i]}});
        end
    end
endmodule

// File: rtl/sbus_regsel.sv
// Register-select decoder: picks one of three IR index fields, with a
// forced last-register override when the opcode is the link-jump code.
// Assumes the opcode sits in the top OPC_W bits of the instruction.
module sbus_regsel #(
    parameter int W = 32,
    parameter int NREG = 16,
    parameter int OPC_W = 5,
    parameter logic [OPC_W-1:0] LINK_OPC = 5'b10100
) (
    input  logic [W-1:0]            ir,
    input  logic                    pick_a,
    input  logic                    pick_b,
    input  logic                    pick_c,
    output logic [$clog2(NREG)-1:0] idx
);
    localparam int IW = $clog2(NREG);
    localparam int A_LO = W - OPC_W - IW;
    localparam int B_LO = A_LO - IW;
    localparam int C_LO = B_LO - IW;
    localparam logic [IW-1:0] LAST = IW'(NREG - 1);

    // Field choice with priority a > b > c, link opcode overrides all
    always_comb begin
        if (ir[W-1 -: OPC_W] == LINK_OPC) idx = LAST;
        else if (pick_a)                  idx = ir[A_LO +: IW];
        else if (pick_b)                  idx = ir[B_LO +: IW];
        else if (pick_c)                  idx = ir[C_LO +: IW];
        else                              idx = '0;
    end
endmodule

// File: rtl/sbus_gpr_bank.sv
// General register bank: NREG words, one shared index for write and read.
// Assumes synchronous active-low reset clears every entry.
module sbus_gpr_bank #(
    parameter int W = 32,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic [W-1:0]            din,
    output logic [W-1:0]            dout
);
    logic [W-1:0] regs [NREG];

    // Write the indexed entry; reset clears all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= din;
        end
    end

    assign dout = regs[idx];
endmodule

// File: rtl/sbus_alu.sv
// Placeholder ALU: A is the Y register, B is the bus. Produces a 2W result:
// full signed product for MUL, {remainder, quotient} for DIV, otherwise a
// sign-extended W-bit result. Unused codes and a zero divisor give 0.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] res
);
    logic [W-1:0]   narrow;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quot;
    logic [W-1:0]   rem;

    // Signed wide product and signed quotient/remainder
    always_comb begin
        prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        if (b == '0) begin
            quot = '0;
            rem  = '0;
        end else begin
            quot = $signed(a) / $signed(b);
            rem  = $signed(a) % $signed(b);
        end
    end

    // Narrow operations
    always_comb begin
        case (op)
            OP_ADD:  narrow = a + b;
            OP_SUB:  narrow = a - b;
            OP_AND:  narrow = a & b;
            OP_OR:   narrow = a | b;
            OP_XOR:  narrow = a ^ b;
            OP_NOT:  narrow = ~b;
            default: narrow = '0;
        endcase
    end

    // Result width select
    always_comb begin
        case (op)
            OP_MUL:  res = prod;
            OP_DIV:  res = {rem, quot};
            default: res = {{W{narrow[W-1]}}, narrow};
        endcase
    end
endmodule

// File: rtl/sbus_datapath.sv
// Single-bus datapath top: PC, IR, MAR, MDR, Y, Z (2W), HI, LO and the
// general register bank on one shared bus. The external sequencer must
// raise at most one output enable per cycle. Reset is synchronous, active-low.
module sbus_datapath
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_pc,
    input  logic              ld_ir,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              ld_y,
    input  logic              ld_z,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              ld_gpr,
    input  logic              oe_pc,
    input  logic              oe_mdr,
    input  logic              oe_zhi,
    input  logic              oe_zlo,
    input  logic              oe_hi,
    input  logic              oe_lo,
    input  logic              oe_gpr,
    input  logic              pick_a,
    input  logic              pick_b,
    input  logic              pick_c,
    input  logic              mem_rd,
    input  logic              y_one,
    input  logic [3:0]        alu_op,
    input  logic [WORD_W-1:0] mem_din,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_dout,
    output logic [WORD_W-1:0] ir_out,
    output logic [WORD_W-1:0] bus_out
);
    localparam int W = WORD_W;
    localparam int IW = $clog2(NUM_GPR);
    localparam int NSRC = 7;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0]   pc_q, ir_q, mar_q, mdr_q, y_q, hi_q, lo_q;
    logic [2*W-1:0] z_q;
    logic [W-1:0]   bus;
    logic [W-1:0]   gpr_rd;
    logic [2*W-1:0] alu_res;
    logic [IW-1:0]  reg_idx;
    logic [NSRC-1:0] oe_vec;

    assign oe_vec = {oe_gpr, oe_lo, oe_hi, oe_zlo, oe_zhi, oe_mdr, oe_pc};

    sbus_bus_mux #(.W(W), .N(NSRC)) u_bus (
        .en  (oe_vec),
        .src ({gpr_rd, lo_q, hi_q, z_q[W-1:0], z_q[2*W-1:W], mdr_q, pc_q}),
        .bus (bus)
    );

    sbus_regsel #(.W(W), .NREG(NUM_GPR), .OPC_W(OPC_W), .LINK_OPC(OPC_LINK)) u_sel (
        .ir     (ir_q),
        .pick_a (pick_a),
        .pick_b (pick_b),
        .pick_c (pick_c),
        .idx    (reg_idx)
    );

    sbus_gpr_bank #(.W(W), .NREG(NUM_GPR)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_gpr),
        .idx   (reg_idx),
        .din   (bus),
        .dout  (gpr_rd)
    );

    sbus_alu #(.W(W)) u_alu (
        .op  (alu_op),
        .a   (y_q),
        .b   (bus),
        .res (alu_res)
    );

    // Bus-loaded registers: PC, IR, MAR
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
        end else begin
            if (ld_pc)  pc_q  <= bus;
            if (ld_ir)  ir_q  <= bus;
            if (ld_mar) mar_q <= bus;
        end
    end

    // MDR and Y through their input selectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            y_q   <= '0;
        end else begin
            if (ld_mdr) mdr_q <= mem_rd ? mem_din : bus;
            if (ld_y)   y_q   <= y_one ? ONE : bus;
        end
    end

    // Result register and its two half-word copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q  <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (ld_z)  z_q  <= alu_res;
            if (ld_hi) hi_q <= z_q[2*W-1:W];
            if (ld_lo) lo_q <= z_q[W-1:0];
        end
    end

    assign mem_addr = mar_q;
    assign mem_dout = mdr_q;
    assign ir_out   = ir_q;
    assign bus_out  = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
// Checker for the single-bus datapath: bus arbitration, register loads,
// input selectors and the link-register override.
module sbus_datapath_chk #(
    parameter int W = 32,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [6:0]    oe_vec,
    input logic [W-1:0]  bus,
    input logic [W-1:0]  pc_q,
    input logic [W-1:0]  mdr_q,
    input logic [W-1:0]  y_q,
    input logic [W-1:0]  ir_q,
    input logic [IW-1:0] reg_idx,
    input logic          ld_pc,
    input logic          ld_mdr,
    input logic          ld_y,
    input logic          y_one,
    input logic          mem_rd,
    input logic [W-1:0]  mem_din
);
    assert_single_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe_vec));

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_vec == '0) |-> (bus == '0));

    assert_pc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc |=> (pc_q == $past(bus)));

    assert_mdr_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mdr && mem_rd) |=> (mdr_q == $past(mem_din)));

    assert_mdr_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mdr && !mem_rd) |=> (mdr_q == $past(bus)));

    assert_y_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_y && y_one) |=> (y_q == W'(1)));

    assert_link_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[W-1 -: 5] == 5'b10100) |-> (reg_idx == {IW{1'b1}}));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(32), .IW(4)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_vec  (oe_vec),
    .bus     (bus),
    .pc_q    (pc_q),
    .mdr_q   (mdr_q),
    .y_q     (y_q),
    .ir_q    (ir_q),
    .reg_idx (reg_idx),
    .ld_pc   (ld_pc),
    .ld_mdr  (ld_mdr),
    .ld_y    (ld_y),
    .y_one   (y_one),
    .mem_rd  (mem_rd),
    .mem_din (mem_din)
);

// File: tb/sbus_datapath_tb.sv
// Directed bench for the single-bus datapath: one task per scenario.
module sbus_datapath_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_pc, ld_ir, ld_mar, ld_mdr, ld_y, ld_z, ld_hi, ld_lo, ld_gpr;
    logic oe_pc, oe_mdr, oe_zhi, oe_zlo, oe_hi, oe_lo, oe_gpr;
    logic pick_a, pick_b, pick_c, mem_rd, y_one;
    logic [3:0]  alu_op;
    logic [31:0] mem_din;
    logic [31:0] mem_addr, mem_dout, ir_out, bus_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam int S_PC = 0, S_MDR = 1, S_ZHI = 2, S_ZLO = 3, S_HI = 4, S_LO = 5, S_GPR = 6;

    always #10 clk = ~clk;

    sbus_datapath u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_y(ld_y),
        .ld_z(ld_z), .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_gpr(ld_gpr),
        .oe_pc(oe_pc), .oe_mdr(oe_mdr), .oe_zhi(oe_zhi), .oe_zlo(oe_zlo),
        .oe_hi(oe_hi), .oe_lo(oe_lo), .oe_gpr(oe_gpr),
        .pick_a(pick_a), .pick_b(pick_b), .pick_c(pick_c),
        .mem_rd(mem_rd), .y_one(y_one), .alu_op(alu_op), .mem_din(mem_din),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .ir_out(ir_out), .bus_out(bus_out)
    );

    task automatic clr();
        {ld_pc, ld_ir, ld_mar, ld_mdr, ld_y, ld_z, ld_hi, ld_lo, ld_gpr} = '0;
        {oe_pc, oe_mdr, oe_zhi, oe_zlo, oe_hi, oe_lo, oe_gpr} = '0;
        {pick_a, pick_b, pick_c, mem_rd, y_one} = '0;
        alu_op = 4'd0;
        mem_din = 32'h0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        clr();
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic peek(input int which, output logic [31:0] v);
        case (which)
            S_PC:    oe_pc  = 1'b1;
            S_MDR:   oe_mdr = 1'b1;
            S_ZHI:   oe_zhi = 1'b1;
            S_ZLO:   oe_zlo = 1'b1;
            S_HI:    oe_hi  = 1'b1;
            S_LO:    oe_lo  = 1'b1;
            default: oe_gpr = 1'b1;
        endcase
        #1;
        v = bus_out;
        clr();
        #1;
    endtask

    task automatic set_mdr(input logic [31:0] v);
        mem_rd = 1'b1; mem_din = v; ld_mdr = 1'b1;
        tick();
    endtask

    task automatic set_ir(input logic [31:0] w);
        set_mdr(w);
        oe_mdr = 1'b1; ld_ir = 1'b1;
        tick();
    endtask

    task automatic set_pc(input logic [31:0] v);
        set_mdr(v);
        oe_mdr = 1'b1; ld_pc = 1'b1;
        tick();
    endtask

    function automatic logic [31:0] ir_word(input logic [4:0] opc, input logic [3:0] fa,
                                            input logic [3:0] fb, input logic [3:0] fc);
        return {opc, fa, fb, fc, 15'h0};
    endfunction

    // Write general register idx through field a (non-link opcode)
    task automatic put_gpr(input logic [3:0] idx, input logic [31:0] v);
        set_ir(ir_word(5'd0, idx, 4'd0, 4'd0));
        set_mdr(v);
        oe_mdr = 1'b1; pick_a = 1'b1; ld_gpr = 1'b1;
        tick();
    endtask

    task automatic get_gpr(input logic [3:0] idx, output logic [31:0] v);
        set_ir(ir_word(5'd0, idx, 4'd0, 4'd0));
        pick_a = 1'b1;
        peek(S_GPR, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1", "mem_addr", mem_addr, 32'h0);
        chk("R1", "mem_dout", mem_dout, 32'h0);
        chk("R1", "ir_out", ir_out, 32'h0);
        #1 chk("R2", "idle bus", bus_out, 32'h0);
        peek(S_PC, v);  chk("R1", "pc", v, 32'h0);
        peek(S_ZHI, v); chk("R1", "z hi", v, 32'h0);
        peek(S_ZLO, v); chk("R1", "z lo", v, 32'h0);
        peek(S_HI, v);  chk("R1", "hi", v, 32'h0);
        peek(S_LO, v);  chk("R1", "lo", v, 32'h0);
        for (int i = 0; i < 16; i++) begin
            pick_c = 1'b0;
            peek(S_GPR, v);
            if (i == 0) chk("R1", "gpr0", v, 32'h0);
        end
        // Read R9 and R15 after reset, using field c
        mem_rd = 1'b1; mem_din = ir_word(5'd0, 4'd0, 4'd0, 4'd9); ld_mdr = 1'b1; tick();
        oe_mdr = 1'b1; ld_ir = 1'b1; tick();
        pick_c = 1'b1; peek(S_GPR, v); chk("R1", "gpr9", v, 32'h0);
        get_gpr(4'd15, v); chk("R1", "gpr15", v, 32'h0);
    endtask

    task automatic t_loads();
        logic [31:0] v;
        set_mdr(32'hA5A5_0001);
        chk("R4", "mdr from memory", mem_dout, 32'hA5A5_0001);
        peek(S_MDR, v); chk("R2", "mdr on bus", v, 32'hA5A5_0001);
        oe_mdr = 1'b1; ld_pc = 1'b1; tick();
        peek(S_PC, v); chk("R3", "pc load", v, 32'hA5A5_0001);
        oe_mdr = 1'b1; ld_mar = 1'b1; tick();
        chk("R3", "mar load", mem_addr, 32'hA5A5_0001);
        set_mdr(32'h0000_7777);
        chk("R3", "mar hold", mem_addr, 32'hA5A5_0001);
        peek(S_PC, v); chk("R3", "pc hold", v, 32'hA5A5_0001);
        // MDR from bus: memory data must be ignored when mem_rd is 0
        oe_pc = 1'b1; ld_mdr = 1'b1; mem_rd = 1'b0; mem_din = 32'hDEAD_BEEF; tick();
        chk("R4", "mdr from bus", mem_dout, 32'hA5A5_0001);
        set_ir(32'h1234_5678);
        chk("R3", "ir load", ir_out, 32'h1234_5678);
    endtask

    task automatic t_pc_inc();
        logic [31:0] v;
        set_pc(32'd41);
        ld_y = 1'b1; y_one = 1'b1; tick();
        oe_pc = 1'b1; alu_op = 4'd0; ld_z = 1'b1; tick();
        oe_zlo = 1'b1; ld_pc = 1'b1; tick();
        peek(S_PC, v); chk("R5", "pc increment", v, 32'd42);
    endtask

    task automatic t_regsel();
        logic [31:0] v;
        put_gpr(4'd3, 32'h0000_0111);
        put_gpr(4'd5, 32'h0000_0555);
        put_gpr(4'd7, 32'h0000_0777);
        set_ir(ir_word(5'd1, 4'd5, 4'd3, 4'd7));
        pick_b = 1'b1; peek(S_GPR, v); chk("R6", "field b", v, 32'h111);
        pick_c = 1'b1; peek(S_GPR, v); chk("R6", "field c", v, 32'h777);
        pick_a = 1'b1; pick_b = 1'b1; pick_c = 1'b1;
        peek(S_GPR, v); chk("R6", "a over b,c", v, 32'h555);
        pick_b = 1'b1; pick_c = 1'b1;
        peek(S_GPR, v); chk("R6", "b over c", v, 32'h111);
    endtask

    task automatic t_link();
        logic [31:0] v;
        put_gpr(4'd2, 32'h0000_0222);
        set_pc(32'h0000_0100);
        set_ir(ir_word(5'b10100, 4'd2, 4'd2, 4'd2));
        oe_pc = 1'b1; pick_a = 1'b1; ld_gpr = 1'b1; tick();
        get_gpr(4'd15, v); chk("R7", "link in r15", v, 32'h0000_0100);
        get_gpr(4'd2, v);  chk("R7", "r2 untouched", v, 32'h0000_0222);
    endtask

    task automatic run_alu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] ehi, input logic [31:0] elo, input string req);
        logic [31:0] v;
        set_mdr(a);
        oe_mdr = 1'b1; ld_y = 1'b1; tick();
        set_mdr(b);
        oe_mdr = 1'b1; alu_op = op; ld_z = 1'b1; tick();
        peek(S_ZHI, v); chk(req, $sformatf("op %0d z hi", op), v, ehi);
        peek(S_ZLO, v); chk(req, $sformatf("op %0d z lo", op), v, elo);
    endtask

    task automatic t_alu();
        run_alu(4'd0, 32'd7, 32'hFFFF_FFFD, 32'h0, 32'd4, "R8");
        run_alu(4'd1, 32'd5, 32'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFC, "R8");
        run_alu(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h0, 32'h00F0_1200, "R8");
        run_alu(4'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFFF_FFFF, 32'hFFF0_FF34, "R8");
        run_alu(4'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFFF_FFFF, 32'hFF00_ED34, "R8");
        run_alu(4'd7, 32'h1234_0000, 32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_FF00, "R8");
        run_alu(4'd2, 32'h0001_0000, 32'h0001_0000, 32'h1, 32'h0, "R9");
        run_alu(4'd2, 32'hFFFF_FFFE, 32'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFA, "R9");
        run_alu(4'd3, 32'd17, 32'd5, 32'd2, 32'd3, "R10");
        run_alu(4'd3, 32'd9, 32'd0, 32'h0, 32'h0, "R10");
        run_alu(4'd12, 32'd9, 32'd4, 32'h0, 32'h0, "R12");
        run_alu(4'd15, 32'hFFFF_FFFF, 32'd1, 32'h0, 32'h0, "R12");
        run_alu(4'd3, 32'hFFFF_FFEF, 32'd5, 32'hFFFF_FFFE, 32'hFFFF_FFFD, "R10");
    endtask

    task automatic t_hilo();
        logic [31:0] v;
        ld_hi = 1'b1; ld_lo = 1'b1; tick();
        peek(S_HI, v); chk("R11", "hi remainder", v, 32'hFFFF_FFFE);
        peek(S_LO, v); chk("R11", "lo quotient", v, 32'hFFFF_FFFD);
    endtask

    initial begin
        clr();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_loads();
        t_pc_inc();
        t_regsel();
        t_link();
        t_alu();
        t_hilo();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule